// File: doc/BRIEF.md
# Debug Register Scan Access Port

This block is a four-wire serial test port, with an active-low test reset, that lets an external debugger read and write a bank of 32-bit debug registers inside the chip. A 16-state controller runs the port. The controller is stepped by the test mode select line on each rising edge of the test clock. Data enters on TDI and leaves on TDO. An instruction register picks the data path. A chain-number register, loaded through a dedicated select instruction, names which scan chain the internal-test instruction connects.

The debug chain is 38 bits long. One shift pass loads three things: a data word in bits 31:0, a register address in bits 36:32, and a direction flag in bit 37. The register access happens when the controller passes through Update-DR. Capture-DR leaves the chain untouched. A write stores the data word. A read replaces the data word with the register contents, and the next shift pass carries that value out on TDO. The system side has its own port into the same register bank. The debug registers have no function inside this block.

Top module: `dbg_tap_access`

## Requirements
- R1: When trst_n is low at a rising TCK edge, the controller goes to Test-Logic-Reset. The same edge sets the instruction to BYPASS (4'hF), clears the chain number to 0, clears the debug shift register and every bank register, and forces tdo and tdo_en to 0.
- R2: Five TCK cycles with TMS high reach Test-Logic-Reset from any state. That state sets the instruction back to BYPASS and the chain number back to 0. The debug shift register and the bank keep their contents.
- R3: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 4'b0001, and Update-IR makes the shifted value the current instruction.
- R4: Instruction 4'hE selects a 32-bit identification register. Capture-DR loads it from the ID parameter.
- R5: Instruction 4'h2 selects a 4-bit chain-number register. Capture-DR loads the current chain number, and Update-DR makes the shifted value the new chain number.
- R6: The debug chain is on the data path only while the instruction is 4'hC and the chain number is 2. At any other time the data path is a 1-bit bypass register that captures 0, and no debug register is accessed.
- R7: The debug chain is 38 bits and shifts least significant bit first. Bits 31:0 hold the data, bits 36:32 the register address, and bit 37 the direction (1 = write, 0 = read).
- R8: Capture-DR does not change the debug shift register. After a write, the next scan pass shifts out exactly the 38 bits that were shifted in.
- R9: At Update-DR with bit 37 = 1, the addressed register takes bits 31:0.
- R10: At Update-DR with bit 37 = 0, bits 31:0 of the shift register take the addressed register's value and bits 37:32 keep their value. The next pass shifts these out.
- R11: A system write (sys_we high at a rising TCK edge) stores sys_wdata at sys_addr. sys_rdata shows the register at sys_addr without delay. When both sides write the same register on the same edge, the debug port wins.
- R12: TDO changes on the falling TCK edge. tdo_en is 1 exactly while the controller is in Shift-IR or Shift-DR. At all other times tdo_en and tdo are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also clocks the system-side port |
| trst_n | input | 1 | Test reset, active low, sampled on rising TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| sys_addr | input | 5 | System-side register address |
| sys_wdata | input | 32 | System-side write data |
| sys_we | input | 1 | System-side write strobe |
| sys_rdata | output | 32 | Register at sys_addr |

## Verification
The properties take tdi, tms and sys_we to be stable around each rising TCK edge. They also take trst_n to start low and to change only between edges. The bench meets this by changing every input just after a falling edge and holding it there. The write and read properties assume that the system port does not write the debug port's target register on the same edge. The stimulus never writes the bank from the system side during a debug scan.

// File: rtl/dbg_tap_pkg.sv
// Shared types and constants for the debug scan access port.
// Assumes a 4-bit instruction register; the opcode values below are fixed encodings.
package dbg_tap_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_SCAN_N  = 4'h2;
    localparam logic [IR_W-1:0] OP_INTEST  = 4'hC;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'hE;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
    } tap_state_e;

endpackage

// File: rtl/dbg_tap_fsm.sv
// Sixteen-state test access controller stepped by TMS on rising TCK.
// Assumes trst_n is sampled synchronously; low forces Test-Logic-Reset.
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state decode of the controller graph.
    always_comb begin
        case (state)
            TLR:     nxt = tms ? TLR    : RTI;
            RTI:     nxt = tms ? SEL_DR : RTI;
            SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
            CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
            SH_DR:   nxt = tms ? EX1_DR : SH_DR;
            EX1_DR:  nxt = tms ? UPD_DR : PA_DR;
            PA_DR:   nxt = tms ? EX2_DR : PA_DR;
            EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
            UPD_DR:  nxt = tms ? SEL_DR : RTI;
            SEL_IR:  nxt = tms ? TLR    : CAP_IR;
            CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
            SH_IR:   nxt = tms ? EX1_IR : SH_IR;
            EX1_IR:  nxt = tms ? UPD_IR : PA_IR;
            PA_IR:   nxt = tms ? EX2_IR : PA_IR;
            EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
            UPD_IR:  nxt = tms ? SEL_DR : RTI;
            default: nxt = TLR;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TLR;
        else         state <= nxt;
    end

endmodule

// File: rtl/dbg_tap_ir.sv
// Instruction register: capture a fixed pattern, shift LSB first, latch on Update-IR.
// Assumes the controller state comes from dbg_tap_fsm in the same clock domain.
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic            ir_so
);

    logic [IR_W-1:0] ir_sr;

    // Shift stage of the instruction register.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_sr <= '0;
        end else if (state == CAP_IR) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == SH_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    // Current instruction; Test-Logic-Reset restores BYPASS.
    always_ff @(posedge tck) begin
        if (!trst_n || state == TLR) begin
            ir <= OP_BYPASS;
        end else if (state == UPD_IR) begin
            ir <= ir_sr;
        end
    end

    assign ir_so = ir_sr[0];

endmodule

// File: rtl/dbg_tap_aux_dr.sv
// Auxiliary data registers: chain-number select, identification and bypass.
// Assumes the debug chain itself lives elsewhere; this block supplies the chain number.
module dbg_tap_aux_dr
    import dbg_tap_pkg::*;
#(
    parameter int          CHAIN_W = 4,
    parameter logic [31:0] ID_CODE = 32'h0A5C_1F3B
) (
    input  logic               tck,
    input  logic               trst_n,
    input  tap_state_e         state,
    input  logic [IR_W-1:0]    ir,
    input  logic               tdi,
    output logic [CHAIN_W-1:0] chain_sel,
    output logic               aux_so
);

    logic [CHAIN_W-1:0] csel_sr;
    logic [31:0]        id_sr;
    logic               byp_sr;

    // Chain-number shift stage: captures the current selection.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            csel_sr <= '0;
        end else if (ir == OP_SCAN_N) begin
            if (state == CAP_DR)     csel_sr <= chain_sel;
            else if (state == SH_DR) csel_sr <= {tdi, csel_sr[CHAIN_W-1:1]};
        end
    end

    // Chain-number register, cleared in Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!trst_n || state == TLR) begin
            chain_sel <= '0;
        end else if (state == UPD_DR && ir == OP_SCAN_N) begin
            chain_sel <= csel_sr;
        end
    end

    // Identification register path.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            id_sr <= '0;
        end else if (ir == OP_IDCODE) begin
            if (state == CAP_DR)     id_sr <= ID_CODE;
            else if (state == SH_DR) id_sr <= {tdi, id_sr[31:1]};
        end
    end

    // One-bit bypass register, captures zero.
    always_ff @(posedge tck) begin
        if (!trst_n)             byp_sr <= 1'b0;
        else if (state == CAP_DR) byp_sr <= 1'b0;
        else if (state == SH_DR)  byp_sr <= tdi;
    end

    // Serial output selection by instruction.
    always_comb begin
        case (ir)
            OP_SCAN_N: aux_so = csel_sr[0];
            OP_IDCODE: aux_so = id_sr[0];
            default:   aux_so = byp_sr;
        endcase
    end

endmodule

// File: rtl/dbg_tap_chain.sv
// Debug access chain: {dir, addr, data} shifted LSB first; access at Update-DR.
// Assumes 'active' is stable across a scan pass (it only changes at Update-IR/DR).
module dbg_tap_chain
    import dbg_tap_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5,
    localparam int W = DW + AW + 1
) (
    input  logic          tck,
    input  logic          trst_n,
    input  tap_state_e    state,
    input  logic          active,
    input  logic          tdi,
    input  logic [DW-1:0] rd_data,
    output logic [W-1:0]  sr,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    output logic          acc_we
);

    logic upd;

    assign upd       = active && (state == UPD_DR);
    assign acc_addr  = sr[W-2:DW];
    assign acc_wdata = sr[DW-1:0];
    assign acc_we    = upd && sr[W-1];

    // Shift register: no capture action, shift in Shift-DR, read load at Update-DR.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            sr <= '0;
        end else if (active) begin
            if (state == SH_DR) begin
                sr <= {tdi, sr[W-1:1]};
            end else if (upd && !sr[W-1]) begin
                sr[DW-1:0] <= rd_data;
            end
        end
    end

endmodule

// File: rtl/dbg_reg_bank.sv
// Behavioural bank of debug registers with a debug port and a system port.
// Assumes both ports share tck; the debug port wins a same-address write collision.
module dbg_reg_bank #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int AW   = 5
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_we,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_we,
    output logic [DW-1:0] b_rdata
);

    logic [DW-1:0] mem [NREG];

    // Storage update; the debug port is applied last so it takes priority.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (b_we && int'(b_addr) < NREG) mem[b_addr] <= b_wdata;
            if (a_we && int'(a_addr) < NREG) mem[a_addr] <= a_wdata;
        end
    end

    // Combinational reads; out-of-range addresses return zero.
    always_comb begin
        a_rdata = (int'(a_addr) < NREG) ? mem[a_addr] : '0;
        b_rdata = (int'(b_addr) < NREG) ? mem[b_addr] : '0;
    end

endmodule

// File: rtl/dbg_tap_access.sv
// Top: test access port with a debug register access chain and a system-side port.
// Assumes a single tck domain for both sides and synchronous trst_n.
module dbg_tap_access
    import dbg_tap_pkg::*;
#(
    parameter int          NREG      = 32,
    parameter int          DW        = 32,
    parameter int          CHAIN_W   = 4,
    parameter int          DBG_CHAIN = 2,
    parameter logic [31:0] ID_CODE   = 32'h0A5C_1F3B,
    localparam int         AW        = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int         W         = DW + AW + 1
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic          tms,
    input  logic          tdi,
    output logic          tdo,
    output logic          tdo_en,
    input  logic [AW-1:0] sys_addr,
    input  logic [DW-1:0] sys_wdata,
    input  logic          sys_we,
    output logic [DW-1:0] sys_rdata
);

    tap_state_e         state;
    logic [IR_W-1:0]    ir;
    logic               ir_so;
    logic [CHAIN_W-1:0] chain_sel;
    logic               aux_so;
    logic               dbg_active;
    logic [W-1:0]       dbg_sr;
    logic [AW-1:0]      acc_addr;
    logic [DW-1:0]      acc_wdata;
    logic               acc_we;
    logic [DW-1:0]      tap_rdata;
    logic               dr_so;

    dbg_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    dbg_tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir     (ir),
        .ir_so  (ir_so)
    );

    dbg_tap_aux_dr #(
        .CHAIN_W (CHAIN_W),
        .ID_CODE (ID_CODE)
    ) u_aux (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (state),
        .ir        (ir),
        .tdi       (tdi),
        .chain_sel (chain_sel),
        .aux_so    (aux_so)
    );

    assign dbg_active = (ir == OP_INTEST) && (chain_sel == CHAIN_W'(DBG_CHAIN));

    dbg_tap_chain #(
        .DW (DW),
        .AW (AW)
    ) u_chain (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (state),
        .active    (dbg_active),
        .tdi       (tdi),
        .rd_data   (tap_rdata),
        .sr        (dbg_sr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_we    (acc_we)
    );

    dbg_reg_bank #(
        .NREG (NREG),
        .DW   (DW),
        .AW   (AW)
    ) u_bank (
        .tck     (tck),
        .trst_n  (trst_n),
        .a_addr  (acc_addr),
        .a_wdata (acc_wdata),
        .a_we    (acc_we),
        .a_rdata (tap_rdata),
        .b_addr  (sys_addr),
        .b_wdata (sys_wdata),
        .b_we    (sys_we),
        .b_rdata (sys_rdata)
    );

    assign dr_so = dbg_active ? dbg_sr[0] : aux_so;

    // Serial output launched on the falling edge of tck.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else if (state == SH_IR) begin
            tdo    <= ir_so;
            tdo_en <= 1'b1;
        end else if (state == SH_DR) begin
            tdo    <= dr_so;
            tdo_en <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_tap_access_chk.sv
// Protocol checker for dbg_tap_access, attached by bind.
// Assumes inputs are stable around rising tck and trst_n starts low.
module dbg_tap_access_chk
    import dbg_tap_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 5,
    parameter int CHAIN_W = 4,
    localparam int W      = DW + AW + 1
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tms,
    input logic               tdi,
    input logic               tdo_en,
    input tap_state_e         state,
    input logic [IR_W-1:0]    ir,
    input logic [CHAIN_W-1:0] chain_sel,
    input logic               dbg_active,
    input logic [W-1:0]       dbg_sr,
    input logic [DW-1:0]      tap_rdata
);

    logic [2:0] hi_cnt;

    // Count consecutive TMS-high edges, saturating at five.
    always_ff @(posedge tck) begin
        if (!trst_n)    hi_cnt <= '0;
        else if (!tms)  hi_cnt <= '0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    assert_tlr_defaults_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR) |=> (ir == OP_BYPASS && chain_sel == '0));

    assert_five_high_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_cnt == 3'd5) |-> (state == TLR));

    assert_idle_chain_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !dbg_active |=> $stable(dbg_sr));

    assert_shift_lsb_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (state == SH_DR && dbg_active) |=> (dbg_sr == {$past(tdi), $past(dbg_sr[W-1:1])}));

    assert_capture_idle_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (state == CAP_DR && dbg_active) |=> $stable(dbg_sr));

    assert_write_lands_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (state == UPD_DR && dbg_active && dbg_sr[W-1]) |=> (tap_rdata == $past(dbg_sr[DW-1:0])));

    assert_read_loads_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (state == UPD_DR && dbg_active && !dbg_sr[W-1]) |=>
        (dbg_sr[DW-1:0] == $past(tap_rdata) && dbg_sr[W-1:DW] == $past(dbg_sr[W-1:DW])));

    assert_tdo_enable_R12: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (state == SH_DR || state == SH_IR));

endmodule

bind dbg_tap_access dbg_tap_access_chk #(
    .DW      (DW),
    .AW      (AW),
    .CHAIN_W (CHAIN_W)
) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tms        (tms),
    .tdi        (tdi),
    .tdo_en     (tdo_en),
    .state      (state),
    .ir         (ir),
    .chain_sel  (chain_sel),
    .dbg_active (dbg_active),
    .dbg_sr     (dbg_sr),
    .tap_rdata  (tap_rdata)
);

// File: tb/dbg_tap_access_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: scan tasks queue expected shift-out words, a monitor compares them.
module dbg_tap_access_bench;

    localparam logic [31:0] ID = 32'h0A5C_1F3B;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo, tdo_en;
    logic [4:0]  sys_addr = '0;
    logic [31:0] sys_wdata = '0;
    logic        sys_we = 1'b0;
    logic [31:0] sys_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 tck = ~tck;

    dbg_tap_access #(.ID_CODE(ID)) u_dbg_tap_access (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en),
        .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_we(sys_we),
        .sys_rdata(sys_rdata)
    );

    typedef struct {
        logic [63:0] val;
        int          n;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] obs;
    event        obs_ev;
    logic        last_en;

    // Reference model of the debug chain and bank.
    logic [37:0] m_sr = '0;
    logic [31:0] m_bank [32];

    function automatic logic [63:0] mk(input logic w, input logic [4:0] a, input logic [31:0] d);
        return 64'({w, a, d});
    endfunction

    function automatic logic [63:0] model_scan(input logic [63:0] din);
        logic [63:0] e;
        e    = 64'(m_sr);
        m_sr = din[37:0];
        if (din[37]) m_bank[din[36:32]] = din[31:0];
        else         m_sr[31:0] = m_bank[din[36:32]];
        return e;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One TCK cycle: drive after the falling edge, sample tdo just before the rising edge.
    task automatic tap_bit(input logic t_ms, input logic t_di, output logic t_do);
        @(negedge tck);
        #0.5;
        tms = t_ms;
        tdi = t_di;
        #1.5;
        t_do    = tdo;
        last_en = tdo_en;
        @(posedge tck);
    endtask

    task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout, output logic en_ok);
        logic o;
        dout  = '0;
        en_ok = 1'b1;
        tap_bit(1'b1, 1'b0, o);
        tap_bit(1'b0, 1'b0, o);
        tap_bit(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            tap_bit(i == n - 1, din[i], o);
            dout[i] = o;
            en_ok   = en_ok & last_en;
        end
        tap_bit(1'b1, 1'b0, o);
        tap_bit(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [63:0] dout);
        logic o;
        dout = '0;
        tap_bit(1'b1, 1'b0, o);
        tap_bit(1'b1, 1'b0, o);
        tap_bit(1'b0, 1'b0, o);
        tap_bit(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            tap_bit(i == 3, op[i], o);
            dout[i] = o;
        end
        tap_bit(1'b1, 1'b0, o);
        tap_bit(1'b0, 1'b0, o);
    endtask

    // Driver tasks: push the expectation, run the scan, publish the result.
    task automatic sb_dr(input logic [63:0] din, input int n, input logic [63:0] exp, input string req);
        logic [63:0] d;
        logic        en;
        sb_q.push_back('{val: exp, n: n, req: req});
        scan_dr(din, n, d, en);
        obs = d;
        ->obs_ev;
    endtask

    task automatic sb_ir(input logic [3:0] op, input string req);
        logic [63:0] d;
        sb_q.push_back('{val: 64'h1, n: 4, req: req});
        scan_ir(op, d);
        obs = d;
        ->obs_ev;
    endtask

    task automatic sb_dbg(input logic [63:0] din, input string req);
        sb_dr(din, 38, model_scan(din), req);
    endtask

    task automatic sys_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge tck);
        #0.5;
        sys_addr  = a;
        sys_wdata = d;
        sys_we    = 1'b1;
        m_bank[a] = d;
        @(posedge tck);
        #0.5;
        sys_we = 1'b0;
    endtask

    task automatic sys_peek(input logic [4:0] a, input string req);
        sys_addr = a;
        #0.1;
        chk(sys_rdata == m_bank[a], req, 64'(sys_rdata), 64'(m_bank[a]));
    endtask

    // Monitor: pop one expectation per published scan result.
    initial begin
        forever begin
            exp_t        e;
            logic [63:0] msk;
            @(obs_ev);
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard-empty", obs, 64'h0);
            end else begin
                e   = sb_q.pop_front();
                msk = (e.n >= 64) ? '1 : ((64'd1 << e.n) - 64'd1);
                chk((obs & msk) == (e.val & msk), e.req, obs & msk, e.val & msk);
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge tck);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic        o;
        logic [63:0] d;
        logic        en;
        for (int i = 0; i < 32; i++) m_bank[i] = '0;

        // R1: reset state at the ports.
        repeat (3) @(posedge tck);
        @(negedge tck);
        #0.5;
        trst_n = 1'b1;
        #0.5;
        chk(tdo_en == 1'b0 && tdo == 1'b0, "R1 tdo idle after reset", {62'b0, tdo_en, tdo}, 64'h0);
        sys_peek(5'd0, "R1 bank cleared");
        tap_bit(1'b0, 1'b0, o);

        // R1, R6: after reset the data path is the 1-bit bypass capturing 0.
        sb_dr(64'hB6, 8, 64'hB6 << 1, "R1 bypass after reset");

        // R3, R4: instruction capture pattern and identification register.
        sb_ir(4'hE, "R3 IR capture");
        sb_dr(64'h0, 32, 64'(ID), "R4 idcode");

        // R5: chain-number register captures the current selection.
        sb_ir(4'h2, "R3 IR capture again");
        sb_dr(64'h2, 4, 64'h0, "R5 chain capture initial");
        sb_dr(64'h2, 4, 64'h2, "R5 chain capture updated");

        // R7, R8, R9: writes through the debug chain.
        sb_ir(4'hC, "R3 IR capture intest");
        sb_dbg(mk(1'b1, 5'd5, 32'hDEAD_BEEF), "R8 capture leaves reset content");
        sys_peek(5'd5, "R9 write reg5");
        sb_dbg(mk(1'b1, 5'd9, 32'h1234_5678), "R7 R8 write echo");
        sys_peek(5'd9, "R9 write reg9");
        sb_dbg(mk(1'b1, 5'd31, 32'h8000_0001), "R7 R8 write echo top address");
        sys_peek(5'd31, "R9 write reg31");

        // R10: reads load the data field; the next pass carries it out.
        sb_dbg(mk(1'b0, 5'd5, 32'hFFFF_FFFF), "R8 echo before read");
        sb_dbg(mk(1'b0, 5'd9, 32'h0), "R10 read reg5");
        sb_dbg(mk(1'b0, 5'd31, 32'h0), "R10 read reg9");

        // R11: system-side write visible through the debug chain.
        sys_write(5'd20, 32'hCAFE_F00D);
        sys_peek(5'd20, "R11 system write");
        sb_dbg(mk(1'b0, 5'd20, 32'h0), "R10 read reg31");
        sb_dbg(mk(1'b1, 5'd0, 32'h0000_0000), "R11 read reg20");

        // R12: enable during shift, idle afterwards.
        scan_dr(mk(1'b0, 5'd0, 32'h0), 38, d, en);
        d = model_scan(mk(1'b0, 5'd0, 32'h0));
        chk(en == 1'b1, "R12 tdo_en during shift", 64'(en), 64'h1);
        chk(tdo_en == 1'b0, "R12 tdo_en idle", 64'(tdo_en), 64'h0);

        // R6: wrong chain number puts bypass on the path and blocks access.
        sb_ir(4'h2, "R3 IR capture select");
        sb_dr(64'h3, 4, 64'h2, "R5 chain before change");
        sb_ir(4'hC, "R3 IR capture intest2");
        sb_dr(mk(1'b1, 5'd5, 32'h1111_1111), 38, mk(1'b1, 5'd5, 32'h1111_1111) << 1, "R6 bypass on wrong chain");
        sys_peek(5'd5, "R6 no write on wrong chain");

        // R2: five TMS-high cycles reset instruction and chain number.
        for (int i = 0; i < 5; i++) tap_bit(1'b1, 1'b0, o);
        tap_bit(1'b0, 1'b0, o);
        sb_dr(64'h5A, 8, 64'h5A << 1, "R2 bypass after TMS reset");
        sb_ir(4'h2, "R3 IR capture after TMS reset");
        sb_dr(64'h2, 4, 64'h0, "R2 chain number cleared");
        sb_ir(4'hC, "R3 IR capture intest3");
        sb_dbg(mk(1'b0, 5'd20, 32'h0), "R2 debug chain kept");

        #20;
        chk(sb_q.size() == 0, "scoreboard drained", 64'(sb_q.size()), 64'h0);
        finish_run();
    end

endmodule